// File: doc/BRIEF.md
# Prescaled Event Timer

This block is an eight-bit up-counter fed by a programmable power-of-two prescaler. Each count event comes either from the instruction-cycle strobe or from a transition on an external pin. A polarity select picks whether a rising or a falling pin transition counts. The pin is resynchronized inside the block. When the count rolls over from its maximum back to zero, a sticky flag is raised.

The prescaler is a single resource with two possible owners. An ownership select gives it either to the timer or to a watchdog event stream, which arrives as an already-synchronous strobe. The same three-bit rate code divides by twice as much when the timer owns it. When the watchdog owns the prescaler, the timer counts every event, so a one-to-one timer rate needs the watchdog to take ownership. The divided watchdog strobe leaves the block for watchdog logic that sits outside it.

Software writes the count directly. A write also resets the prescaler when the timer owns it. It also opens a short gap in which events are not counted.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count reads 00h and the overflow flag reads 0. The prescaler holds zero.
- R2: With `src_ext`=0, each clock cycle in which `cyc_en` is 1 is one event. Cycles with `cyc_en`=0 add nothing.
- R3: With `src_ext`=1, only synchronized pin transitions are events, and `cyc_en` produces no count. With `edge_fall`=1 only high-to-low transitions count; with `edge_fall`=0 only low-to-high ones count. A pin change made between clock edges shows in `count` after the third following rising clock edge.
- R4: With `psa_wdt`=0 (timer owns the prescaler), the count advances once per 2^(`rate`+1) events. For example, rate 0 divides by 2 and rate 7 divides by 256.
- R5: With `psa_wdt`=1, the count advances on every event. In the same cycle, `wdt_tick` is 1 on every 2^`rate`-th cycle with `wdt_en`=1, and it is 0 whenever `wdt_en`=0.
- R6: With `psa_wdt`=0, `wdt_tick` follows `wdt_en` undivided.
- R7: `cnt_wr`=1 loads `cnt_wdata` into the count at the next clock edge. The load takes priority over an event in the same cycle.
- R8: A write while `psa_wdt`=0 returns the prescaler to zero. A write while `psa_wdt`=1 leaves the prescaler's progress untouched.
- R9: The first two `cyc_en` strobes after a write add nothing to the count. While the timer owns the prescaler, those strobes do not advance the prescaler either.
- R10: An increment from FFh to 00h sets `ovf_flag`, which stays set until `flag_clr`. A rollover in the same cycle as `flag_clr` leaves the flag set. A count write does not change the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_en | input | 1 | Instruction-cycle strobe |
| wdt_en | input | 1 | Watchdog event strobe, synchronous to `clk` |
| ext_pin | input | 1 | Raw external count pin |
| src_ext | input | 1 | 1 = count pin transitions, 0 = count `cyc_en` |
| edge_fall | input | 1 | 1 = falling pin edges, 0 = rising |
| psa_wdt | input | 1 | 1 = watchdog owns prescaler, 0 = timer owns it |
| rate | input | 3 | Prescaler rate code |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write data |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky rollover flag |
| wdt_tick | output | 1 | Watchdog strobe after prescaling |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 3-bit rate code, a two-stage pin synchronizer and a two-strobe write gap. Because the count is only eight bits, a write near FFh puts a rollover within a few events. The /256 ratio is measured over about a thousand strobes. The short synchronizer makes the three-edge pin latency checkable on exact cycles. With the two-strobe gap, each blocked strobe after a write can be observed one at a time.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic {
    SRC_CYCLE = 1'b0,
    SRC_PIN   = 1'b1
  } ptmr_src_e;

  typedef enum logic {
    OWNER_TIMER = 1'b0,
    OWNER_WDOG  = 1'b1
  } ptmr_owner_e;
endpackage

// File: rtl/ptmr_edge.sv
module ptmr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_ev
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q, sync_d;
  logic         prev_q, prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = pin;
    end else begin : g_chain
      always_comb sync_d = {sync_q[TOP-1:0], pin};
    end
  endgenerate

  always_comb prev_d = sync_q[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    if (fall_sel) edge_ev = prev_q & ~sync_q[TOP];
    else          edge_ev = sync_q[TOP] & ~prev_q;
  end

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev && $stable(fall_sel) |=> !edge_ev) else $error("edge pulse too long"); // R3
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ev,
  input  logic              wdt_en,
  input  logic              psa_wdt,
  input  logic [RATE_W-1:0] rate,
  input  logic              clr,
  output logic              tmr_tick,
  output logic              wdt_tick
);
  import ptmr_pkg::*;
  localparam int PRE_W = 2 ** RATE_W;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W:0]   one_hot;
  logic [PRE_W-1:0] mask_wdt, mask_tmr, mask;
  logic             owner_ev, at_top;
  ptmr_owner_e      owner;

  always_comb begin
    owner    = ptmr_owner_e'(psa_wdt);
    one_hot  = (PRE_W+1)'(1) << rate;
    mask_wdt = PRE_W'(one_hot - (PRE_W+1)'(1));
    mask_tmr = PRE_W'((one_hot << 1) - (PRE_W+1)'(1));
    mask     = (owner == OWNER_WDOG) ? mask_wdt : mask_tmr;
    owner_ev = (owner == OWNER_WDOG) ? wdt_en : tmr_ev;
    at_top   = (pre_q & mask) == mask;
  end

  always_comb begin
    pre_d = pre_q;
    if (clr)           pre_d = '0;
    else if (owner_ev) pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_comb begin
    if (owner == OWNER_WDOG) begin
      tmr_tick = tmr_ev;
      wdt_tick = wdt_en & at_top;
    end else begin
      tmr_tick = tmr_ev & at_top;
      wdt_tick = wdt_en;
    end
  end

  AST_WDT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |-> !wdt_tick) else $error("watchdog tick without strobe"); // R5
  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pre_q == '0) else $error("prescaler not cleared"); // R8
  AST_TICK_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |-> tmr_ev) else $error("timer tick without event"); // R4
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 8,
  parameter int GAP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             hold
);
  localparam int GW = $clog2(GAP + 1);

  logic [CNT_W-1:0] count_q, count_d;
  logic             ovf_q, ovf_d;
  logic [GW-1:0]    gap_q, gap_d;
  logic             wrap;

  always_comb begin
    wrap    = tick & ~cnt_wr & (count_q == '1);
    count_d = count_q;
    if (cnt_wr)    count_d = wdata;
    else if (tick) count_d = count_q + CNT_W'(1);

    ovf_d = ovf_q;
    if (wrap)          ovf_d = 1'b1;
    else if (flag_clr) ovf_d = 1'b0;

    gap_d = gap_q;
    if (cnt_wr)                        gap_d = GW'(GAP);
    else if (cyc_en && gap_q != '0)    gap_d = gap_q - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      gap_q   <= '0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
      gap_q   <= gap_d;
    end
  end

  always_comb begin
    count = count_q;
    ovf   = ovf_q;
    hold  = gap_q != '0;
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_q == $past(wdata)) else $error("write not loaded"); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !flag_clr |=> ovf_q) else $error("flag dropped"); // R10
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr && count_q == '1 |=> ovf_q && count_q == '0) else $error("rollover lost"); // R10
  AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !tick) else $error("tick right after write"); // R9
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W       = 8,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int WR_GAP      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              wdt_en,
  input  logic              ext_pin,
  input  logic              src_ext,
  input  logic              edge_fall,
  input  logic              psa_wdt,
  input  logic [RATE_W-1:0] rate,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_flag,
  output logic              wdt_tick
);
  import ptmr_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       pin_ev, raw_ev, tmr_ev, hold, tick, pre_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  always_comb rst_core_n = rst_pipe_q[1];

  ptmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_core_n), .pin(ext_pin), .fall_sel(edge_fall), .edge_ev(pin_ev)
  );

  always_comb begin
    raw_ev  = (ptmr_src_e'(src_ext) == SRC_PIN) ? pin_ev : cyc_en;
    tmr_ev  = raw_ev & ~hold;
    pre_clr = cnt_wr & (ptmr_owner_e'(psa_wdt) == OWNER_TIMER);
  end

  ptmr_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk(clk), .rst_n(rst_core_n), .tmr_ev(tmr_ev), .wdt_en(wdt_en),
    .psa_wdt(psa_wdt), .rate(rate), .clr(pre_clr),
    .tmr_tick(tick), .wdt_tick(wdt_tick)
  );

  ptmr_counter #(.CNT_W(CNT_W), .GAP(WR_GAP)) u_cnt (
    .clk(clk), .rst_n(rst_core_n), .cyc_en(cyc_en), .tick(tick),
    .cnt_wr(cnt_wr), .wdata(cnt_wdata), .flag_clr(flag_clr),
    .count(count), .ovf(ovf_flag), .hold(hold)
  );
endmodule

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, cyc_en, wdt_en, ext_pin, src_ext, edge_fall, psa_wdt;
  logic [2:0] rate;
  logic       cnt_wr, flag_clr;
  logic [7:0] cnt_wdata, count;
  logic       ovf_flag, wdt_tick;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_timer uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wdt_en(wdt_en), .ext_pin(ext_pin),
    .src_ext(src_ext), .edge_fall(edge_fall), .psa_wdt(psa_wdt), .rate(rate),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
    .count(count), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cyc_en = 0; wdt_en = 0; ext_pin = 0; src_ext = 0; edge_fall = 0;
    psa_wdt = 1; rate = 0; cnt_wr = 0; cnt_wdata = 0; flag_clr = 0;
    tick_n(2);
    rst_n = 1'b1;
    tick_n(3);
  endtask

  task automatic ev_n(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc_en = 1'b1; tick_n(1); cyc_en = 1'b0;
      if (gap > 0) tick_n(gap);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; tick_n(1); cnt_wr = 1'b0;
  endtask

  task automatic wdt_pulses(input int n, output int ticks);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      wdt_en = 1'b1; #1;
      if (wdt_tick) ticks++;
      tick_n(1); wdt_en = 1'b0;
    end
  endtask

  task automatic test_reset();
    do_reset();
    chk("R1 count", count, 8'h00);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 wdt_tick idle", wdt_tick, 0);
  endtask

  task automatic test_timer_rates();
    int rl[3] = '{0, 3, 7};
    do_reset();
    psa_wdt = 0; src_ext = 0;
    foreach (rl[k]) begin
      int div;
      rate = 3'(rl[k]);
      div = 2 << rl[k];
      wr(8'h00);
      ev_n(2 + 3*div + div - 1, 1);   // R2: idle cycles between strobes add nothing
      chk($sformatf("R4 R2 rate %0d", rl[k]), count, 3);
    end
  endtask

  task automatic test_wdt_owned();
    do_reset();
    psa_wdt = 1; src_ext = 0; rate = 3'd5;
    wr(8'h05);
    ev_n(12, 0);
    chk("R5 timer one-to-one", count, 8'h0F);
    wr(8'h20);
    ev_n(1, 0); chk("R9 first strobe blocked", count, 8'h20);
    ev_n(1, 0); chk("R9 second strobe blocked", count, 8'h20);
    ev_n(1, 0); chk("R9 third strobe counted", count, 8'h21);
    cyc_en = 1'b1; wr(8'h40); cyc_en = 1'b0;
    chk("R7 write beats event", count, 8'h40);
  endtask

  task automatic test_wdt_tick();
    int t;
    do_reset();
    psa_wdt = 1; rate = 3'd2;
    wdt_pulses(2, t); chk("R5 no tick before 4th", t, 0);
    wr(8'h33);
    wdt_pulses(2, t); chk("R8 owned write keeps prescaler", t, 1);
    rate = 3'd0;
    wdt_pulses(5, t); chk("R5 rate0 every strobe", t, 5);
    psa_wdt = 0; rate = 3'd6;
    wdt_pulses(3, t); chk("R6 undivided", t, 3);
    #1; chk("R6 idle low", wdt_tick, 0);
  endtask

  task automatic test_clear_prescaler();
    do_reset();
    psa_wdt = 0; src_ext = 0; rate = 3'd3;
    wr(8'h00); ev_n(12, 0);
    chk("R8 partial progress", count, 0);
    wr(8'h00); ev_n(17, 0);
    chk("R8 R9 cleared no early tick", count, 0);
    ev_n(1, 0);
    chk("R8 tick on 16th", count, 1);
  endtask

  task automatic test_ext();
    do_reset();
    psa_wdt = 1; src_ext = 1; edge_fall = 0; cyc_en = 1'b1;
    wr(8'h00); tick_n(4);
    chk("R3 strobe ignored", count, 0);
    ext_pin = 1'b1; tick_n(2);
    chk("R3 not yet", count, 0);
    tick_n(1);
    chk("R3 rising counted", count, 1);
    ext_pin = 1'b0; tick_n(5);
    chk("R3 falling ignored", count, 1);
    edge_fall = 1'b1;
    ext_pin = 1'b1; tick_n(5);
    chk("R3 rising ignored", count, 1);
    ext_pin = 1'b0; tick_n(5);
    chk("R3 falling counted", count, 2);
    cyc_en = 1'b0;
  endtask

  task automatic test_overflow();
    do_reset();
    psa_wdt = 1; src_ext = 0;
    wr(8'hFD);
    ev_n(4, 0);
    chk("R10 at FF", count, 8'hFF); chk("R10 flag low", ovf_flag, 0);
    ev_n(1, 0);
    chk("R10 wrapped", count, 8'h00); chk("R10 flag set", ovf_flag, 1);
    ev_n(3, 0);
    chk("R10 flag sticky", ovf_flag, 1);
    flag_clr = 1'b1; tick_n(1); flag_clr = 1'b0;
    chk("R10 flag cleared", ovf_flag, 0);
    wr(8'hFF); ev_n(2, 0);
    cyc_en = 1'b1; flag_clr = 1'b1; tick_n(1); cyc_en = 1'b0; flag_clr = 1'b0;
    chk("R10 set beats clear", ovf_flag, 1);
    wr(8'h10);
    chk("R10 write keeps flag", ovf_flag, 1);
  endtask

  initial begin
    test_reset();
    test_timer_rates();
    test_wdt_owned();
    test_wdt_tick();
    test_clear_prescaler();
    test_ext();
    test_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule